// File: doc/BRIEF.md
# Three-Row Pixel Column Feeder

This block sits between a row-oriented pixel fetcher and a 3x3 neighbourhood operator such as an edge-detection mask. It keeps a small cache for each of three vertically adjacent image rows: the row above, the row being worked on and the row below. Each cache holds one word of four 8-bit pixels. All three caches are loaded together in one handshake, with one word per row. The block then sends the cached pixels out as a stream of vertical columns. Each column carries one pixel from each row, one column per clock, ready to be shifted into the operator's window registers.

Streaming is tied to the video timing. A frame may begin only once three rows exist, so no column leaves the block until the third horizontal sync rising edge of the frame has been seen. A vertical sync ends the frame. It drops the enable, throws away any cached pixels not yet sent and restarts the line count. While streaming, the block asks for the next word during the cycle in which the last cached pixel is taken. A fetcher that answers in the same cycle therefore keeps the column stream free of gaps. A word offered while the caches still hold unsent pixels is held off by the ready signal.

Top module: `tri_row_feeder`

## Requirements
- R1: During and straight after reset, `col_valid` is 0, and `refill_req` and `fill_ready` are both 1 because the caches are empty.
- R2: A word is taken only in a cycle with `fill_valid` and `fill_ready` both high. That one transfer loads all three row caches, and the four pixels of a word leave in the order bits [7:0], [15:8], [23:16], [31:24], one per column.
- R3: Each column is packed as `col_data[23:16]` = previous-row pixel, `[15:8]` = current-row pixel, `[7:0]` = next-row pixel. Pixels are passed unchanged as unsigned 8-bit values, and `col_valid` marks every cycle that carries a column.
- R4: No column is sent before the third hsync rising edge since reset or the last vsync. After that edge, a column is sent on every clock edge at which the caches hold a pixel and vsync is low.
- R5: `refill_req` is 1 when the caches are empty, or when one pixel remains and streaming is enabled. A fetcher that answers in that same cycle therefore gives an unbroken run of `col_valid`.
- R6: `fill_ready` is 0 while two or more pixels remain, while one pixel remains and streaming is disabled, and in any cycle with vsync high. A word offered at such a time is not taken, and the stream carries only the older pixels.
- R7: A vsync high at a clock edge clears the hsync count and discards every unsent cached pixel. `col_valid` is 0 from the next cycle until three more hsync rising edges have been seen.
- R8: Only rising edges of hsync are counted, so hsync held high for several cycles counts once. Rising edges after the third do not disturb streaming.
- R9: A word accepted before streaming is enabled is kept intact and leaves first once the third hsync edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync | input | 1 | Horizontal sync; rising edges count rows |
| vsync | input | 1 | Vertical sync; ends the frame |
| fill_valid | input | 1 | A word for each of the three rows is offered |
| fill_ready | output | 1 | The caches will take the offered words at this edge |
| fill_prev | input | 32 | Four pixels of the previous row |
| fill_cur | input | 32 | Four pixels of the current row |
| fill_next | input | 32 | Four pixels of the next row |
| refill_req | output | 1 | Request for the next set of words |
| col_valid | output | 1 | `col_data` holds a new column |
| col_data | output | 24 | Column {previous, current, next} |

## Verification
The hardest case to reach is the cycle in which the last cached pixel is shifted out while a new word is loaded and a vsync or extra hsync arrives nearby. The outcome depends on the order of reload, shift and flush at one edge. The stimulus sweeps the fetcher's answer period from every cycle to every fifth cycle, and puts surplus hsync edges at a fixed stride so that they land at every cache fill level. It then drops vsync in the middle of a word. A bench-side model of the cache occupancy and line count predicts every ready, request and column value in each cycle.

// File: rtl/tri_row_pkg.sv
package tri_row_pkg;
    localparam int NROWS    = 3;
    localparam int IDX_PREV = 0;
    localparam int IDX_CUR  = 1;
    localparam int IDX_NEXT = 2;
endpackage

// File: rtl/sync_start_gate.sv
module sync_start_gate #(
    parameter int START_LINES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hsync,
    input  logic vsync,
    output logic stream_en
);
    localparam int CW = $clog2(START_LINES + 1);
    localparam logic [CW-1:0] CMAX = CW'(START_LINES);

    typedef struct packed {
        logic          hs;
        logic [CW-1:0] cnt;
    } gate_st_t;

    gate_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.hs = hsync;
        if (vsync) begin
            st_d.cnt = '0;
        end else if (hsync && !st_q.hs && st_q.cnt != CMAX) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stream_en = (st_q.cnt == CMAX);

    // R7: a frame end always removes the enable
    a_r7_vsync_clears_enable: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !stream_en);

    // R8: a held-high hsync adds nothing to the line count
    a_r8_level_not_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (hsync && st_q.hs && !vsync) |=> $stable(st_q.cnt));
endmodule

// File: rtl/cache_fill_ctrl.sv
module cache_fill_ctrl #(
    parameter int WORD_PIX = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stream_en,
    input  logic vsync,
    input  logic fill_valid,
    output logic fill_ready,
    output logic refill_req,
    output logic load,
    output logic shift
);
    localparam int LW = $clog2(WORD_PIX + 1);
    localparam logic [LW-1:0] FULL = LW'(WORD_PIX);
    localparam logic [LW-1:0] ONE  = LW'(1);
    localparam logic [LW-1:0] TWO  = LW'(2);

    typedef struct packed {
        logic [LW-1:0] left;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        refill_req = (st_q.left == '0) || (st_q.left == ONE && stream_en);
        fill_ready = refill_req && !vsync;
        shift      = stream_en && !vsync && (st_q.left != '0);
        load       = fill_valid && fill_ready;

        st_d = st_q;
        if (vsync) begin
            st_d.left = '0;
        end else if (load) begin
            st_d.left = FULL;
        end else if (shift) begin
            st_d.left = st_q.left - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: a word is never taken while unsent pixels would be lost
    a_r6_full_blocks_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.left > ONE) |-> !fill_ready);

    // R2: an accepted transfer leaves the caches holding a whole word
    a_r2_load_fills_word: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && fill_ready) |=> (st_q.left == FULL));

    // R5: the request is raised while the last pixel is being taken
    a_r5_early_request: assert property (@(posedge clk) disable iff (!rst_n)
        (stream_en && !vsync && st_q.left == TWO) |=> refill_req);

    // R2: occupancy never exceeds one word
    a_r2_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.left <= FULL);
endmodule

// File: rtl/pixel_lane.sv
module pixel_lane #(
    parameter int PIX_W    = 8,
    parameter int WORD_PIX = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      shift,
    input  logic [WORD_PIX*PIX_W-1:0] word,
    output logic [PIX_W-1:0]          head
);
    localparam int LANE_W = WORD_PIX * PIX_W;

    typedef struct packed {
        logic [LANE_W-1:0] bits;
    } lane_st_t;

    lane_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.bits = word;
        end else if (shift) begin
            st_d.bits = st_q.bits >> PIX_W;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head = st_q.bits[PIX_W-1:0];
endmodule

// File: rtl/tri_row_feeder.sv
module tri_row_feeder
    import tri_row_pkg::*;
#(
    parameter int PIX_W       = 8,
    parameter int WORD_PIX    = 4,
    parameter int START_LINES = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hsync,
    input  logic                       vsync,
    input  logic                       fill_valid,
    output logic                       fill_ready,
    input  logic [WORD_PIX*PIX_W-1:0]  fill_prev,
    input  logic [WORD_PIX*PIX_W-1:0]  fill_cur,
    input  logic [WORD_PIX*PIX_W-1:0]  fill_next,
    output logic                       refill_req,
    output logic                       col_valid,
    output logic [NROWS*PIX_W-1:0]     col_data
);
    localparam int WORD_W = WORD_PIX * PIX_W;
    localparam int COL_W  = NROWS * PIX_W;

    typedef struct packed {
        logic             vld;
        logic [COL_W-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    logic              stream_en;
    logic              load;
    logic              shift;
    logic [WORD_W-1:0] words [NROWS];
    logic [PIX_W-1:0]  heads [NROWS];

    assign words[IDX_PREV] = fill_prev;
    assign words[IDX_CUR]  = fill_cur;
    assign words[IDX_NEXT] = fill_next;

    sync_start_gate #(.START_LINES(START_LINES)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .hsync     (hsync),
        .vsync     (vsync),
        .stream_en (stream_en)
    );

    cache_fill_ctrl #(.WORD_PIX(WORD_PIX)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .stream_en  (stream_en),
        .vsync      (vsync),
        .fill_valid (fill_valid),
        .fill_ready (fill_ready),
        .refill_req (refill_req),
        .load       (load),
        .shift      (shift)
    );

    for (genvar r = 0; r < NROWS; r++) begin : g_lane
        pixel_lane #(.PIX_W(PIX_W), .WORD_PIX(WORD_PIX)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .shift (shift),
            .word  (words[r]),
            .head  (heads[r])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = shift;
        if (shift) begin
            for (int r = 0; r < NROWS; r++) begin
                st_d.data[(NROWS-1-r)*PIX_W +: PIX_W] = heads[r];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign col_valid = st_q.vld;
    assign col_data  = st_q.data;

    // R4: a column only follows a cycle in which streaming was enabled
    a_r4_column_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid |-> $past(stream_en));

    // R7: the cycle after a frame end carries no column
    a_r7_vsync_stops_stream: assert property (@(posedge clk) disable iff (!rst_n)
        vsync |=> !col_valid);
endmodule

// File: tb/tb_tri_row_feeder.sv
module tb_tri_row_feeder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hsync, vsync, fill_valid;
    logic        fill_ready, refill_req, col_valid;
    logic [31:0] fill_prev, fill_cur, fill_next;
    logic [23:0] col_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_row_feeder dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .vsync      (vsync),
        .fill_valid (fill_valid),
        .fill_ready (fill_ready),
        .fill_prev  (fill_prev),
        .fill_cur   (fill_cur),
        .fill_next  (fill_next),
        .refill_req (refill_req),
        .col_valid  (col_valid),
        .col_data   (col_data)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    logic [23:0] q [$];
    int          wseq = 0;
    int          hcnt = 0;
    logic        hs_prev = 1'b0;
    logic        exp_cv = 1'b0;
    logic [23:0] exp_cd = '0;

    function automatic logic [7:0] pix(int s, int r, int k);
        return 8'((s * 37 + r * 101 + k * 59 + 11) & 255);
    endfunction

    function automatic logic [31:0] word_of(int s, int r);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[k*8 +: 8] = pix(s, r, k);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic hs, input logic vs, input logic fv);
        logic exp_rdy, exp_req;
        @(negedge clk);
        chk(col_valid === exp_cv, "R4/R5/R7 col_valid", 32'(col_valid), 32'(exp_cv));
        if (exp_cv) chk(col_data === exp_cd, "R2/R3/R9 column", 32'(col_data), 32'(exp_cd));
        hsync      = hs;
        vsync      = vs;
        fill_valid = fv;
        fill_prev  = word_of(wseq, 0);
        fill_cur   = word_of(wseq, 1);
        fill_next  = word_of(wseq, 2);
        #1;
        exp_req = (q.size() == 0) || (q.size() == 1 && hcnt >= 3);
        exp_rdy = exp_req && !vs;
        chk(refill_req === exp_req, "R5 refill_req", 32'(refill_req), 32'(exp_req));
        chk(fill_ready === exp_rdy, "R6 fill_ready", 32'(fill_ready), 32'(exp_rdy));
        exp_cv = !vs && hcnt >= 3 && q.size() > 0;
        if (exp_cv) exp_cd = q.pop_front();
        if (vs) q.delete();
        if (fv && exp_rdy) begin
            for (int k = 0; k < 4; k++)
                q.push_back({pix(wseq, 0, k), pix(wseq, 1, k), pix(wseq, 2, k)});
            wseq++;
        end
        if (vs) hcnt = 0;
        else if (hs && !hs_prev && hcnt < 3) hcnt++;
        hs_prev = hs;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hsync = 0; vsync = 0; fill_valid = 0;
        fill_prev = '0; fill_cur = '0; fill_next = '0;
        repeat (3) @(negedge clk);
        chk(col_valid === 1'b0, "R1 col_valid in reset", 32'(col_valid), 0);
        chk(refill_req === 1'b1, "R1 refill_req in reset", 32'(refill_req), 1);
        chk(fill_ready === 1'b1, "R1 fill_ready in reset", 32'(fill_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_valid === 1'b0, "R1 col_valid after reset", 32'(col_valid), 0);

        // R9/R6: one word taken before streaming, further offers refused
        repeat (3) step(0, 0, 1);
        step(1, 0, 1);
        step(0, 0, 1);
        // R8: hsync held high counts once
        repeat (4) step(1, 0, 0);
        repeat (3) step(0, 0, 1);
        // R4: third rising edge starts the stream
        step(1, 0, 1);
        repeat (40) step(0, 0, 1);

        // R5/R8: fetcher answer period sweep with surplus hsync edges
        for (int per = 1; per <= 5; per++)
            for (int i = 0; i < 24; i++)
                step((i % 7) == 3, 0, (i % per) == 0);

        // R7: vsync in the middle of a word
        repeat (2) step(0, 0, 1);
        step(0, 1, 1);
        repeat (3) step(0, 0, 1);
        step(1, 0, 1); step(0, 0, 1);
        step(1, 0, 1); step(0, 0, 1);
        repeat (3) step(0, 0, 1);
        step(1, 0, 1);
        repeat (20) step(0, 0, 1);

        // R7: vsync together with hsync, then restart
        step(1, 1, 0);
        step(0, 0, 1);
        for (int n = 0; n < 3; n++) begin
            step(1, 0, 0);
            step(0, 0, 0);
        end
        repeat (12) step(0, 0, 1);
        repeat (8) step(0, 0, 0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule